// File: doc/BRIEF.md
# Partitioned Packed SIMD Adder

This block adds or subtracts two 64-bit words that each hold a packed vector of integers. One control picks the element width for the whole word: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes, or one 64-bit lane. Lanes of different widths share the same bits. For example, bytes 0 and 1 together are the bits of 16-bit element 0. Element i of width w sits at bits `[i*w +: w]`, so element 0 is at the least significant end.

The datapath is one ripple of 8-bit slices. At each slice border the carry either passes upward or is replaced by the start-of-lane carry. The element-size select decides which. No carry crosses a lane edge. Each lane returns its result modulo 2^w and one status bit. The status bit is an unsigned carry-out or a signed overflow, chosen per operation. The block has no clock and no state. Its outputs follow its inputs.

Top module: `simd_lane_adder`

## Requirements
- R1: `elem_sz` picks the element width: 0 gives 8-bit lanes, 1 gives 16-bit, 2 gives 32-bit and 3 gives one 64-bit lane. Lane i covers bits `[i*w +: w]`. With all inputs zero, `sum_o` and `flag_o` are zero.
- R2: With `sub_en` = 0, each lane of `sum_o` equals (A_lane + B_lane) mod 2^w.
- R3: With `sub_en` = 1, each lane of `sum_o` equals (A_lane - B_lane) mod 2^w. Subtracting equal operands gives zero.
- R4: No carry or borrow crosses a lane edge. A lane's result depends only on that lane's operand bits and on the controls.
- R5: With `signed_en` = 0, a lane's flag is the carry-out of A + B + cin, where B is inverted and cin is 1 for subtract. For add it is 1 when the true sum reaches 2^w. For subtract it is 1 when A >= B, treating both as unsigned.
- R6: With `signed_en` = 1, a lane's flag is 1 exactly when the two's-complement result does not fit in w bits.
- R7: The flag of lane i sits in `flag_o` bit (i+1)*(w/8)-1, the slot of the lane's top byte. All other bits of `flag_o` are zero.
- R8: The block is purely combinational. Outputs settle from the current inputs without any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 64 | Packed operand A |
| opd_b | input | 64 | Packed operand B (the subtrahend when subtracting) |
| elem_sz | input | 2 | Element width select: 0=8, 1=16, 2=32, 3=64 bits |
| sub_en | input | 1 | 1 computes A-B per lane, 0 computes A+B |
| signed_en | input | 1 | 1 reports signed overflow, 0 reports unsigned carry-out |
| sum_o | output | 64 | Packed per-lane result |
| flag_o | output | 8 | Per-lane status in the slot of each lane's top byte |

## Verification
The bench drives patterns built around carry propagation. These include all-ones plus one, 0x80 and 0x7F bytes, and alternating halves. It runs them under every width, operation and signedness, and compares each lane against arithmetic done separately in the bench.

Several faults would show up here. If a lane edge failed to cut the chain, the carry would leak into the next lane's low bit. If subtraction skipped the injected one at lane starts, every difference would come out one too low. If overflow used the wrong bits, sign-boundary cases such as 0x7F+0x01 or 0x80-0x01 would be misflagged. If a flag landed in the wrong slot, it would appear at a lower byte index, or a non-top slot would read nonzero.

// File: rtl/simd_lane_adder.sv
module simd_lane_adder #(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 8
) (
  input  logic [DATA_W-1:0]                              opd_a,
  input  logic [DATA_W-1:0]                              opd_b,
  input  logic [$clog2($clog2(DATA_W/SLICE_W)+1)-1:0]    elem_sz,
  input  logic                                           sub_en,
  input  logic                                           signed_en,
  output logic [DATA_W-1:0]                              sum_o,
  output logic [DATA_W/SLICE_W-1:0]                      flag_o
);
  localparam int NSL  = DATA_W / SLICE_W;
  localparam int SZ_W = $clog2($clog2(NSL) + 1);
  localparam logic [SZ_W-1:0] SZ_MAX = SZ_W'($clog2(NSL));

  logic [NSL:0]   carry;
  logic [NSL-1:0] lane_lo, lane_hi;
  logic [31:0]    grp_mask;

  assign grp_mask = (32'd1 << elem_sz) - 32'd1;
  assign carry[0] = sub_en;

  for (genvar k = 0; k < NSL; k++) begin : g_slice
    logic [SLICE_W-1:0] a_s, b_x, s_s;
    logic               c_in, ovf;

    assign lane_lo[k] = ((32'(k) & grp_mask) == 32'd0);
    assign lane_hi[k] = ((32'(k + 1) & grp_mask) == 32'd0);
    assign a_s  = opd_a[k*SLICE_W +: SLICE_W];
    assign b_x  = opd_b[k*SLICE_W +: SLICE_W] ^ {SLICE_W{sub_en}};
    assign c_in = lane_lo[k] ? sub_en : carry[k];
    assign {carry[k+1], s_s} = {1'b0, a_s} + {1'b0, b_x} + (SLICE_W+1)'(c_in);
    assign ovf  = (a_s[SLICE_W-1] == b_x[SLICE_W-1]) && (s_s[SLICE_W-1] != a_s[SLICE_W-1]);
    assign sum_o[k*SLICE_W +: SLICE_W] = s_s;
    assign flag_o[k] = lane_hi[k] & (signed_en ? ovf : carry[k+1]);
  end

  always_comb begin
    if (!$isunknown({opd_a, opd_b, elem_sz, sub_en, signed_en})) begin
      AST_FLAG_COUNT: assert ($countones(flag_o) <= (NSL >> elem_sz)); // R7
      AST_SELF_SUB_ZERO: assert (!(sub_en && opd_a == opd_b) || sum_o == '0); // R3
      if (elem_sz == SZ_MAX) begin
        AST_FULL_WIDTH: assert (sum_o == (sub_en ? opd_a - opd_b : opd_a + opd_b)); // R2
      end
      if (elem_sz == '0) begin
        for (int k = 0; k < NSL; k++) begin
          AST_BYTE_ISOLATION: assert (sum_o[k*SLICE_W +: SLICE_W] ==
            (sub_en ? opd_a[k*SLICE_W +: SLICE_W] - opd_b[k*SLICE_W +: SLICE_W]
                    : opd_a[k*SLICE_W +: SLICE_W] + opd_b[k*SLICE_W +: SLICE_W])); // R4
        end
      end
    end
  end
endmodule

// File: tb/sim_simd_lane_adder.sv
module sim_simd_lane_adder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [63:0] opd_a, opd_b, sum_o;
  logic [1:0]  elem_sz;
  logic        sub_en, signed_en;
  logic [7:0]  flag_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  simd_lane_adder u0 (.opd_a(opd_a), .opd_b(opd_b), .elem_sz(elem_sz), .sub_en(sub_en),
                      .signed_en(signed_en), .sum_o(sum_o), .flag_o(flag_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic ref_model(input logic [63:0] a, b, input logic [1:0] sz, input logic sb, sg,
                           output logic [63:0] es, output logic [7:0] ef);
    int w = 8 << sz;
    logic [64:0] m = (65'd1 << w) - 65'd1;
    es = '0; ef = '0;
    for (int i = 0; i < 64 / w; i++) begin
      logic [64:0] al, bl, bo, s, r;
      logic sa, sbit, sr, ov;
      al = {1'b0, a >> (i*w)} & m;
      bl = {1'b0, b >> (i*w)} & m;
      bo = sb ? (~bl & m) : bl;
      s  = al + bo + 65'(sb);
      r  = s & m;
      es = es | (r[63:0] << (i*w));
      sa = al[w-1]; sbit = bl[w-1]; sr = r[w-1];
      ov = sb ? (sa != sbit && sr != sa) : (sa == sbit && sr != sa);
      ef[(i+1)*(w/8)-1] = sg ? ov : s[w];
    end
  endtask

  task automatic run(input logic [63:0] a, b, input logic [1:0] sz, input logic sb, sg);
    logic [63:0] es; logic [7:0] ef;
    ref_model(a, b, sz, sb, sg, es, ef);
    opd_a = a; opd_b = b; elem_sz = sz; sub_en = sb; signed_en = sg;
    #1;
    n_chk++;
    if (sum_o !== es) begin
      n_fail++;
      if (sb) $display("FAIL R3 R4 sz=%0d a=%h b=%h sum=%h expected %h", sz, a, b, sum_o, es);
      else    $display("FAIL R2 R4 sz=%0d a=%h b=%h sum=%h expected %h", sz, a, b, sum_o, es);
    end
    n_chk++;
    if (flag_o !== ef) begin
      n_fail++;
      if (sg) $display("FAIL R6 R7 sz=%0d sub=%0d a=%h b=%h flag=%b expected %b", sz, sb, a, b, flag_o, ef);
      else    $display("FAIL R5 R7 sz=%0d sub=%0d a=%h b=%h flag=%b expected %b", sz, sb, a, b, flag_o, ef);
    end
    #1;
  endtask

  task automatic all_modes(input logic [63:0] a, b);
    for (int sz = 0; sz < 4; sz++)
      for (int m = 0; m < 4; m++)
        run(a, b, 2'(sz), m[0], m[1]);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual hung, expected completion");
    finish_up();
  end

  initial begin
    // R1 R8: zero inputs give zero outputs, no clock edge needed
    opd_a = '0; opd_b = '0; elem_sz = '0; sub_en = 0; signed_en = 0;
    #1;
    n_chk++;
    if (sum_o !== '0 || flag_o !== '0) begin
      n_fail++;
      $display("FAIL R1 zero state sum=%h flag=%b expected 0 0", sum_o, flag_o);
    end
    // R8: output follows an input change without a clock edge
    opd_a = 64'h1; opd_b = 64'h2; #1;
    n_chk++;
    if (sum_o !== 64'h3) begin
      n_fail++;
      $display("FAIL R8 sum=%h expected %h", sum_o, 64'h3);
    end
    // R4 R5 R6: carry-edge corners
    all_modes('1, 64'h0101_0101_0101_0101);
    all_modes('1, 64'h1);
    all_modes(64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080);
    all_modes(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101);
    all_modes(64'h8000_0000_8000_0000, 64'h0000_0001_0000_0001);
    all_modes(64'hFFFF_0000_FFFF_0000, 64'h0001_FFFF_0001_FFFF);
    all_modes(64'h0, 64'h0101_0101_0101_0101);
    all_modes(64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
    all_modes(64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF);
    // R2 R3: byte-value sweep, replicated with per-byte offsets
    for (int x = 0; x < 256; x += 5)
      for (int y = 0; y < 256; y += 7) begin
        logic [63:0] a, b;
        for (int i = 0; i < 8; i++) begin
          a[i*8 +: 8] = 8'(x + i * 37);
          b[i*8 +: 8] = 8'(y + i * 11);
        end
        all_modes(a, b);
      end
    // R2 R3 R5 R6: random vectors
    for (int n = 0; n < 300; n++)
      all_modes({$urandom, $urandom}, {$urandom, $urandom});
    finish_up();
  end
endmodule